// File: doc/BRIEF.md
# Parallel Load/Store Extension Unit

This block executes the small side operation packed into the low byte of a 16-bit DSP instruction word, in parallel with whatever arithmetic the upper byte encodes. The side operations step an address pointer, copy an accumulator part into an operand register, store a register to data memory, load memory into a register, perform a combined load and store, or load two operand halves at once. The block owns four address pointers, four index registers, four operand-register halves (two operand registers, each split into low and high) and the low, middle and high parts of two accumulators.

Every register result of the side operation is gathered into a write-back set during the instruction and committed on the clock edge that ends it. All reads inside the instruction, both memory addresses and register sources, therefore see the values from before the instruction. The main datapath reads the register file through a read port, which shows those old values during the whole instruction. It writes its own results through a write port.

Data memory is reached through two asynchronous read ports and one write port that commits on the same clock edge as the registers.

Top module: `ext_unit`

## Requirements
- R1: Only instr_i[7:0] selects the side operation. The upper byte instr_i[15:8] has no effect on any register or memory write.
- R2: Low byte 0000 01rr subtracts 1 from pointer r, 0000 10rr adds 1, and 0000 11rr adds index register r (16-bit, wrapping). Any low byte 0000 00xx changes nothing.
- R3: Low byte 0001 ddss copies accumulator part ss into operand half dd. Accumulator part codes are 00 acc0 low, 01 acc1 low, 10 acc0 mid, 11 acc1 mid. Operand half codes are 00 op0 low, 01 op1 low, 10 op0 high, 11 op1 high.
- R4: Low byte 001s snpp writes accumulator part ss (R3 codes) to memory at pointer pp, with mem_we_o high for that cycle. Pointer pp then gets +1 when n=0 or +index pp when n=1. No other family except R7 raises mem_we_o.
- R5: Low byte 01ddd npp loads memory at pointer pp into data register ddd, then steps pp as in R4. The ddd codes are 000–011 the operand halves in R3 order, then 100 acc0 low, 101 acc1 low, 110 acc0 mid, 111 acc1 mid.
- R6: When wide_mode_i is high and an R5 load targets acc0 mid or acc1 mid, the word goes to that mid part. The high part of the same accumulator gets bit 15 of the word replicated, and its low part is cleared.
- R7: Low byte 10dd mnxs stores acc0 mid (s=0) or acc1 mid (s=1) and loads operand half dd (R3 codes). With x=0 the store goes through pointer 3 and the load through pointer 0. With x=1 the two pointers swap roles. Pointer 0 gets +index 0 when n=1, otherwise +1. Pointer 3 gets +index 3 when m=1, otherwise +1.
- R8: Low byte 11dr mnpp loads op0 low (d=0) or op0 high (d=1) from memory at pointer pp. It loads op1 low (r=0) or op1 high (r=1) from memory at pointer 3. Pointer pp gets +index pp when n=1, otherwise +1. Pointer 3 gets +index 3 when m=1, otherwise +1. When pp is 3, pointer 3 is stepped once, by the n rule.
- R9: In an R8 load, when address bits 15:10 of pointer pp and pointer 3 are equal, the word read through pointer pp is written to both destinations.
- R10: Every memory address, store value and register source in an instruction uses the register values from before it. main_rdata_o shows the old value while the instruction is applied, and a load reads memory as it was before a store in the same instruction.
- R11: main_we_i writes main_wdata_i to register main_wsel_i at the clock edge. Select codes are 0–3 pointers, 4–7 index registers, and 8 plus an R5 code for ddd, with 16 acc0 high and 17 acc1 high. A side-operation write to the same register in the same cycle wins.
- R12: An active-low asynchronous reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word; one instruction per cycle |
| wide_mode_i | input | 1 | Sign-extending accumulator load mode |
| mem_raddr_a_o | output | 16 | Read address, first pointer |
| mem_rdata_a_i | input | 16 | Read data for mem_raddr_a_o |
| mem_raddr_b_o | output | 16 | Read address, pointer 3 |
| mem_rdata_b_i | input | 16 | Read data for mem_raddr_b_o |
| mem_we_o | output | 1 | Memory write enable |
| mem_waddr_o | output | 16 | Memory write address |
| mem_wdata_o | output | 16 | Memory write data |
| main_rsel_i | input | 5 | Main datapath register read select |
| main_rdata_o | output | 16 | Main datapath register read data |
| main_we_i | input | 1 | Main datapath register write enable |
| main_wsel_i | input | 5 | Main datapath register write select |
| main_wdata_i | input | 16 | Main datapath register write data |

## Verification
The assertions assume that read data from memory is settled and known within the cycle its address is driven. The register-result assertions only apply when the main datapath is not writing in the same cycle, so they make no claim when a main write could overlap the side-operation write. The stimulus drives a fully known instruction every cycle and enables main writes in about one cycle in five. It masks random pointer values written by the main datapath into a few memory areas, so that dual loads with shared and separate areas both occur often. Directed cases cover same-address load and store, a dual load through pointer 3 alone, negative sign-extended loads, and a main write colliding with a pointer step.

// File: rtl/ext_pkg.sv
package ext_pkg;
  localparam int unsigned N_PTR = 4;
  localparam int unsigned N_DAT = 10;
  localparam int unsigned N_REG = 2 * N_PTR + N_DAT;
  localparam int unsigned PTR_W = $clog2(N_PTR);
  localparam int unsigned DAT_W = $clog2(N_DAT);
  localparam int unsigned SEL_W = $clog2(N_REG);

  // data register codes; the order of 0..7 is fixed by the load encoding
  localparam logic [DAT_W-1:0] D_OP0L = 4'd0;
  localparam logic [DAT_W-1:0] D_OP1L = 4'd1;
  localparam logic [DAT_W-1:0] D_OP0H = 4'd2;
  localparam logic [DAT_W-1:0] D_OP1H = 4'd3;
  localparam logic [DAT_W-1:0] D_AC0M = 4'd6;
  localparam logic [DAT_W-1:0] D_AC1M = 4'd7;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2,
    STEP_IDX  = 2'd3
  } step_e;

  typedef struct packed {
    logic                   ld_a;
    logic [PTR_W-1:0]       ptr_a;
    logic [DAT_W-1:0]       dst_a;
    logic                   wide_a;
    logic                   ld_b;
    logic [DAT_W-1:0]       dst_b;
    logic                   dual;
    logic                   st;
    logic [PTR_W-1:0]       ptr_st;
    logic [DAT_W-1:0]       src_st;
    logic                   mv;
    logic [DAT_W-1:0]       src_mv;
    logic [DAT_W-1:0]       dst_mv;
    step_e [N_PTR-1:0]      step;
  } ctrl_t;
endpackage

// File: rtl/ext_decode.sv
module ext_decode
  import ext_pkg::*;
(
  input  logic [7:0] op_i,
  output ctrl_t      ctrl_o
);
  ctrl_t c;

  always_comb begin
    c = '0;
    casez (op_i)
      8'b11??_????: begin  // dual load
        c.ld_a  = 1'b1;
        c.ptr_a = op_i[1:0];
        c.dst_a = op_i[5] ? D_OP0H : D_OP0L;
        c.ld_b  = 1'b1;
        c.dst_b = op_i[4] ? D_OP1H : D_OP1L;
        c.dual  = 1'b1;
        c.step[N_PTR-1]   = op_i[3] ? STEP_IDX : STEP_INC;
        // when pp is pointer 3 this overrides: one step, by the n rule
        c.step[op_i[1:0]] = op_i[2] ? STEP_IDX : STEP_INC;
      end
      8'b10??_????: begin  // load plus store
        c.ld_a   = 1'b1;
        c.dst_a  = {2'b00, op_i[5:4]};
        c.ptr_a  = op_i[1] ? PTR_W'(N_PTR - 1) : '0;
        c.st     = 1'b1;
        c.ptr_st = op_i[1] ? '0 : PTR_W'(N_PTR - 1);
        c.src_st = op_i[0] ? D_AC1M : D_AC0M;
        c.step[0]       = op_i[2] ? STEP_IDX : STEP_INC;
        c.step[N_PTR-1] = op_i[3] ? STEP_IDX : STEP_INC;
      end
      8'b01??_????: begin  // single load
        c.ld_a   = 1'b1;
        c.ptr_a  = op_i[1:0];
        c.dst_a  = {1'b0, op_i[5:3]};
        c.wide_a = 1'b1;
        c.step[op_i[1:0]] = op_i[2] ? STEP_IDX : STEP_INC;
      end
      8'b001?_????: begin  // single store
        c.st     = 1'b1;
        c.ptr_st = op_i[1:0];
        c.src_st = {2'b01, op_i[4:3]};
        c.step[op_i[1:0]] = op_i[2] ? STEP_IDX : STEP_INC;
      end
      8'b0001_????: begin  // move
        c.mv     = 1'b1;
        c.dst_mv = {2'b00, op_i[3:2]};
        c.src_mv = {2'b01, op_i[1:0]};
      end
      8'b0000_01??: c.step[op_i[1:0]] = STEP_DEC;
      8'b0000_10??: c.step[op_i[1:0]] = STEP_INC;
      8'b0000_11??: c.step[op_i[1:0]] = STEP_IDX;
      default: ;
    endcase
  end

  assign ctrl_o = c;
endmodule

// File: rtl/ext_agu.sv
module ext_agu
  import ext_pkg::*;
#(
  parameter int unsigned XLEN = 16
) (
  input  logic  [N_PTR-1:0][XLEN-1:0] ar_i,
  input  logic  [N_PTR-1:0][XLEN-1:0] ix_i,
  input  step_e [N_PTR-1:0]           step_i,
  output logic  [N_PTR-1:0][XLEN-1:0] ar_nxt_o,
  output logic  [N_PTR-1:0]           ar_we_o
);
  for (genvar i = 0; i < N_PTR; i++) begin : g_ptr
    always_comb begin
      ar_we_o[i]  = 1'b1;
      ar_nxt_o[i] = ar_i[i];
      unique case (step_i[i])
        STEP_INC:  ar_nxt_o[i] = ar_i[i] + XLEN'(1);
        STEP_DEC:  ar_nxt_o[i] = ar_i[i] - XLEN'(1);
        STEP_IDX:  ar_nxt_o[i] = ar_i[i] + ix_i[i];
        default:   ar_we_o[i]  = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ext_regfile.sv
module ext_regfile
  import ext_pkg::*;
#(
  parameter int unsigned XLEN = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        main_we_i,
  input  logic [SEL_W-1:0]            main_wsel_i,
  input  logic [XLEN-1:0]             main_wdata_i,
  input  logic [SEL_W-1:0]            main_rsel_i,
  output logic [XLEN-1:0]             main_rdata_o,
  input  logic [N_PTR-1:0]            ar_we_i,
  input  logic [N_PTR-1:0][XLEN-1:0]  ar_nxt_i,
  input  logic [N_DAT-1:0]            dat_we_i,
  input  logic [N_DAT-1:0][XLEN-1:0]  dat_nxt_i,
  output logic [N_PTR-1:0][XLEN-1:0]  ar_o,
  output logic [N_PTR-1:0][XLEN-1:0]  ix_o,
  output logic [N_DAT-1:0][XLEN-1:0]  dat_o
);
  localparam int unsigned IX_BASE  = N_PTR;
  localparam int unsigned DAT_BASE = 2 * N_PTR;

  logic [N_PTR-1:0][XLEN-1:0] ar_q, ix_q;
  logic [N_DAT-1:0][XLEN-1:0] dat_q;

  // side-operation write-back is applied after the main write, so it wins
  for (genvar i = 0; i < N_PTR; i++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ar_q[i] <= '0;
        ix_q[i] <= '0;
      end else begin
        if (main_we_i && main_wsel_i == SEL_W'(i)) ar_q[i] <= main_wdata_i;
        if (ar_we_i[i]) ar_q[i] <= ar_nxt_i[i];
        if (main_we_i && main_wsel_i == SEL_W'(IX_BASE + i)) ix_q[i] <= main_wdata_i;
      end
    end
  end

  for (genvar i = 0; i < N_DAT; i++) begin : g_dat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dat_q[i] <= '0;
      end else begin
        if (main_we_i && main_wsel_i == SEL_W'(DAT_BASE + i)) dat_q[i] <= main_wdata_i;
        if (dat_we_i[i]) dat_q[i] <= dat_nxt_i[i];
      end
    end
  end

  always_comb begin
    main_rdata_o = '0;
    for (int i = 0; i < N_PTR; i++) begin
      if (main_rsel_i == SEL_W'(i))           main_rdata_o = ar_q[i];
      if (main_rsel_i == SEL_W'(IX_BASE + i)) main_rdata_o = ix_q[i];
    end
    for (int i = 0; i < N_DAT; i++) begin
      if (main_rsel_i == SEL_W'(DAT_BASE + i)) main_rdata_o = dat_q[i];
    end
  end

  assign ar_o  = ar_q;
  assign ix_o  = ix_q;
  assign dat_o = dat_q;

  // R11: index registers are written only by the main datapath
  p_main_ix_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_we_i && main_wsel_i >= SEL_W'(IX_BASE) && main_wsel_i < SEL_W'(DAT_BASE))
    |=> ix_q[$past(main_wsel_i[PTR_W-1:0])] == $past(main_wdata_i));
endmodule

// File: rtl/ext_unit.sv
module ext_unit
  import ext_pkg::*;
#(
  parameter int unsigned XLEN     = 16,
  parameter int unsigned AREA_LSB = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [15:0]      instr_i,
  input  logic             wide_mode_i,
  output logic [XLEN-1:0]  mem_raddr_a_o,
  input  logic [XLEN-1:0]  mem_rdata_a_i,
  output logic [XLEN-1:0]  mem_raddr_b_o,
  input  logic [XLEN-1:0]  mem_rdata_b_i,
  output logic             mem_we_o,
  output logic [XLEN-1:0]  mem_waddr_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  input  logic [SEL_W-1:0] main_rsel_i,
  output logic [XLEN-1:0]  main_rdata_o,
  input  logic             main_we_i,
  input  logic [SEL_W-1:0] main_wsel_i,
  input  logic [XLEN-1:0]  main_wdata_i
);
  ctrl_t                      ctl;
  logic [N_PTR-1:0][XLEN-1:0] ar_q, ix_q, ar_nxt;
  logic [N_PTR-1:0]           ar_we;
  logic [N_DAT-1:0][XLEN-1:0] dat_q, dat_nxt;
  logic [N_DAT-1:0]           dat_we;
  logic                       same_area;
  logic                       wide_hit;

  ext_decode u_dec (
    .op_i   (instr_i[7:0]),
    .ctrl_o (ctl)
  );

  ext_agu #(.XLEN(XLEN)) u_agu (
    .ar_i     (ar_q),
    .ix_i     (ix_q),
    .step_i   (ctl.step),
    .ar_nxt_o (ar_nxt),
    .ar_we_o  (ar_we)
  );

  ext_regfile #(.XLEN(XLEN)) u_rf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .main_we_i    (main_we_i),
    .main_wsel_i  (main_wsel_i),
    .main_wdata_i (main_wdata_i),
    .main_rsel_i  (main_rsel_i),
    .main_rdata_o (main_rdata_o),
    .ar_we_i      (ar_we),
    .ar_nxt_i     (ar_nxt),
    .dat_we_i     (dat_we),
    .dat_nxt_i    (dat_nxt),
    .ar_o         (ar_q),
    .ix_o         (ix_q),
    .dat_o        (dat_q)
  );

  // all addresses and sources come from pre-instruction state
  assign mem_raddr_a_o = ar_q[ctl.ptr_a];
  assign mem_raddr_b_o = ar_q[N_PTR-1];
  assign mem_we_o      = ctl.st;
  assign mem_waddr_o   = ar_q[ctl.ptr_st];
  assign mem_wdata_o   = dat_q[ctl.src_st];

  assign same_area = ctl.dual &&
    (mem_raddr_a_o[XLEN-1:AREA_LSB] == mem_raddr_b_o[XLEN-1:AREA_LSB]);
  assign wide_hit  = ctl.wide_a && wide_mode_i && (ctl.dst_a[DAT_W-1:1] == 3'b011);

  // write-back set, committed at the end of the instruction
  always_comb begin
    dat_we  = '0;
    dat_nxt = dat_q;
    if (ctl.mv) begin
      dat_we[ctl.dst_mv]  = 1'b1;
      dat_nxt[ctl.dst_mv] = dat_q[ctl.src_mv];
    end
    if (ctl.ld_a) begin
      dat_we[ctl.dst_a]  = 1'b1;
      dat_nxt[ctl.dst_a] = mem_rdata_a_i;
      if (wide_hit) begin
        dat_we[{3'b100, ctl.dst_a[0]}]  = 1'b1;
        dat_nxt[{3'b100, ctl.dst_a[0]}] = {XLEN{mem_rdata_a_i[XLEN-1]}};
        dat_we[{3'b010, ctl.dst_a[0]}]  = 1'b1;
        dat_nxt[{3'b010, ctl.dst_a[0]}] = '0;
      end
    end
    if (ctl.ld_b) begin
      dat_we[ctl.dst_b]  = 1'b1;
      dat_nxt[ctl.dst_b] = same_area ? mem_rdata_a_i : mem_rdata_b_i;
    end
  end

  // R1: a no-op low byte leaves state alone whatever the upper byte holds
  p_hi_ignored_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[7:2] == 6'b0 && instr_i[15:8] != 8'h00 && !main_we_i)
    |=> $stable(ar_q) && $stable(dat_q));

  // R2: decrement of the addressed pointer
  p_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[7:2] == 6'b000001 && !main_we_i)
    |=> ar_q[$past(instr_i[1:0])] == $past(ar_q[instr_i[1:0]]) - XLEN'(1));

  // R4: only store families drive the write port
  p_store_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (instr_i[7:5] == 3'b001 || instr_i[7:6] == 2'b10));

  // R6: sign-extending load into an accumulator mid part
  p_wide_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[7:4] == 4'b0111 && wide_mode_i && !main_we_i)
    |=> dat_q[{3'b100, $past(instr_i[3])}] == {XLEN{$past(mem_rdata_a_i[XLEN-1])}}
        && dat_q[{3'b010, $past(instr_i[3])}] == '0);

  // R9: same area gives both dual-load targets one word
  p_same_area_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[7:6] == 2'b11 && !main_we_i &&
     ar_q[instr_i[1:0]][XLEN-1:AREA_LSB] == ar_q[N_PTR-1][XLEN-1:AREA_LSB])
    |=> dat_q[{2'b00, $past(instr_i[5]), 1'b0}] == dat_q[{2'b00, $past(instr_i[4]), 1'b1}]);
endmodule

// File: tb/ext_unit_test.sv
module ext_unit_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr, main_wdata, main_rdata;
  logic        sr40, main_we, we;
  logic [4:0]  main_wsel, main_rsel;
  logic [15:0] raddr_a, raddr_b, rdata_a, rdata_b, waddr, wdata;
  logic [15:0] mem [256];

  int    checks = 0;
  int    fails = 0;
  string last_tag = "R12";

  logic [15:0] m_r [18];
  logic [15:0] n_r [18];
  logic        exp_we;
  logic [15:0] exp_waddr, exp_wdata;

  always #5 clk = ~clk;

  function automatic logic [7:0] hix(input logic [15:0] a);
    return a[7:0] ^ a[15:8];
  endfunction

  assign rdata_a = mem[hix(raddr_a)];
  assign rdata_b = mem[hix(raddr_b)];
  always @(posedge clk) if (we) mem[hix(waddr)] <= wdata;

  ext_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr), .wide_mode_i(sr40),
    .mem_raddr_a_o(raddr_a), .mem_rdata_a_i(rdata_a),
    .mem_raddr_b_o(raddr_b), .mem_rdata_b_i(rdata_b),
    .mem_we_o(we), .mem_waddr_o(waddr), .mem_wdata_o(wdata),
    .main_rsel_i(main_rsel), .main_rdata_o(main_rdata),
    .main_we_i(main_we), .main_wsel_i(main_wsel), .main_wdata_i(main_wdata)
  );

  function automatic logic [15:0] rd(input logic [15:0] a);
    return mem[hix(a)];
  endfunction

  function automatic logic [15:0] upd(input logic [15:0] a, input logic [15:0] ix, input logic idx);
    return idx ? a + ix : a + 16'd1;
  endfunction

  function automatic string fam(input logic [7:0] b);
    if (b[7:6] == 2'b11) return "R8";
    if (b[7:6] == 2'b10) return "R7";
    if (b[7:6] == 2'b01) return "R5";
    if (b[7:5] == 3'b001) return "R4";
    if (b[7:4] == 4'b0001) return "R3";
    return "R2";
  endfunction

  // reference model: register codes 0-3 ptr, 4-7 index, 8+ddd data, 16/17 acc high
  task automatic model(input logic [7:0] b, input logic sr, input logic mwe,
                       input logic [4:0] msel, input logic [15:0] mwd);
    logic [15:0] va, vb;
    int s, d;
    for (int k = 0; k < 18; k++) n_r[k] = m_r[k];
    exp_we = 1'b0; exp_waddr = '0; exp_wdata = '0;
    if (mwe && msel < 5'd18) n_r[msel] = mwd;
    s = int'(b[1:0]);
    if (b[7:6] == 2'b11) begin
      va = rd(m_r[s]);
      vb = (m_r[s][15:10] == m_r[3][15:10]) ? va : rd(m_r[3]);
      n_r[b[5] ? 10 : 8] = va;
      n_r[b[4] ? 11 : 9] = vb;
      n_r[3] = upd(m_r[3], m_r[7], b[3]);
      n_r[s] = upd(m_r[s], m_r[4+s], b[2]);
    end else if (b[7:6] == 2'b10) begin
      exp_we = 1'b1;
      exp_waddr = b[1] ? m_r[0] : m_r[3];
      exp_wdata = m_r[14 + int'(b[0])];
      n_r[8 + int'(b[5:4])] = rd(b[1] ? m_r[3] : m_r[0]);
      n_r[0] = upd(m_r[0], m_r[4], b[2]);
      n_r[3] = upd(m_r[3], m_r[7], b[3]);
    end else if (b[7:6] == 2'b01) begin
      va = rd(m_r[s]);
      d = int'(b[5:3]);
      n_r[8+d] = va;
      if (sr && d >= 6) begin
        n_r[10+d] = {16{va[15]}};
        n_r[6+d]  = 16'h0000;
      end
      n_r[s] = upd(m_r[s], m_r[4+s], b[2]);
    end else if (b[7:5] == 3'b001) begin
      exp_we = 1'b1;
      exp_waddr = m_r[s];
      exp_wdata = m_r[12 + int'(b[4:3])];
      n_r[s] = upd(m_r[s], m_r[4+s], b[2]);
    end else if (b[7:4] == 4'b0001) begin
      n_r[8 + int'(b[3:2])] = m_r[12 + s];
    end else begin
      case (b[3:2])
        2'b01: n_r[s] = m_r[s] - 16'd1;
        2'b10: n_r[s] = m_r[s] + 16'd1;
        2'b11: n_r[s] = m_r[s] + m_r[4+s];
        default: ;
      endcase
    end
  endtask

  // reads every register through the main read port while the next instruction
  // is already applied: checks the previous result and R10 old-value visibility
  task automatic sweep(input string t);
    int bad = -1;
    logic [15:0] got = '0;
    for (int k = 0; k < 18; k++) begin
      main_rsel = 5'(k);
      #0.2;
      if (bad < 0 && main_rdata !== m_r[k]) begin
        bad = k;
        got = main_rdata;
      end
    end
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s/R10 reg %0d: got %h expected %h", t, bad, got, m_r[bad]);
    end
  endtask

  task automatic step(input logic [15:0] ins, input logic sr, input logic mwe,
                      input logic [4:0] msel, input logic [15:0] mwd, input string t);
    string mt;
    @(negedge clk);
    instr = ins; sr40 = sr; main_we = mwe; main_wsel = msel; main_wdata = mwd;
    #0.1;
    sweep(last_tag);
    model(ins[7:0], sr, mwe, msel, mwd);
    mt = (ins[7:6] == 2'b10) ? "R7" : "R4";
    checks++;
    if (we !== exp_we || (exp_we && (waddr !== exp_waddr || wdata !== exp_wdata))) begin
      fails++;
      $display("FAIL %s write port: got we=%b a=%h d=%h expected we=%b a=%h d=%h",
               mt, we, waddr, wdata, exp_we, exp_waddr, exp_wdata);
    end
    for (int k = 0; k < 18; k++) m_r[k] = n_r[k];
    last_tag = t;
  endtask

  task automatic mw(input int sel, input logic [15:0] v);
    step(16'h0000, 1'b0, 1'b1, 5'(sel), v, "R11");
  endtask

  initial begin
    logic [15:0] ins, mwd;
    logic [4:0]  msel;
    logic        mwe;
    void'($urandom(32'h1357_2468));
    instr = '0; sr40 = 1'b0; main_we = 1'b0; main_wsel = '0; main_wdata = '0; main_rsel = '0;
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    for (int k = 0; k < 18; k++) m_r[k] = '0;
    mem[hix(16'h0010)] = 16'h9abc;
    repeat (2) @(negedge clk);
    sweep("R12");  // reset state
    rst_ni = 1'b1;

    // preload through the main write port (R11)
    mw(0, 16'h0010); mw(1, 16'h0820); mw(2, 16'h0011); mw(3, 16'h0012);
    mw(4, 16'h0002); mw(5, 16'hffff); mw(6, 16'h0003); mw(7, 16'hfffe);
    mw(12, 16'h1111); mw(13, 16'h2222); mw(14, 16'h8333); mw(15, 16'h4444);
    // R1: upper byte does not matter
    step(16'hab00, 1'b0, 1'b0, 0, 0, "R1");
    step(16'hff5a, 1'b0, 1'b0, 0, 0, "R1");
    // R2: steps and no-op
    step(16'h0003, 1'b0, 1'b0, 0, 0, "R2");
    step(16'h0005, 1'b0, 1'b0, 0, 0, "R2");
    step(16'h000a, 1'b0, 1'b0, 0, 0, "R2");
    step(16'h000f, 1'b0, 1'b0, 0, 0, "R2");
    // R3: move acc1 mid to op0 high
    step(16'h001b, 1'b0, 1'b0, 0, 0, "R3");
    // R4: store acc0 mid through ptr 1, both step kinds
    step(16'h0031, 1'b0, 1'b0, 0, 0, "R4");
    step(16'h0035, 1'b0, 1'b0, 0, 0, "R4");
    // R5 / R6: load from 0x0010 into acc0 mid, plain and wide
    mw(0, 16'h0010);
    step(16'h0070, 1'b0, 1'b0, 0, 0, "R5");
    mw(0, 16'h0010);
    step(16'h0070, 1'b1, 1'b0, 0, 0, "R6");
    step(16'h0078, 1'b1, 1'b0, 0, 0, "R6");
    // R7: load/store, plain and mirrored with both index additions
    step(16'h0080, 1'b0, 1'b0, 0, 0, "R7");
    step(16'h009e, 1'b0, 1'b0, 0, 0, "R7");
    // R10: load and store on one address read old memory
    mw(0, 16'h0040); mw(3, 16'h0040);
    step(16'h0091, 1'b0, 1'b0, 0, 0, "R10");
    mw(0, 16'h0040);
    step(16'h0050, 1'b0, 1'b0, 0, 0, "R10");
    // R8 / R9: dual loads, separate areas, shared area, through ptr 3 alone
    mw(1, 16'h0823); mw(3, 16'h0012);
    step(16'h00c1, 1'b0, 1'b0, 0, 0, "R8");
    mw(1, 16'h0030);
    step(16'h00f5, 1'b0, 1'b0, 0, 0, "R9");
    step(16'h00f7, 1'b0, 1'b0, 0, 0, "R8");
    step(16'h00db, 1'b0, 1'b0, 0, 0, "R8");
    // R11: main write collides with a pointer step; the step wins
    step(16'h000a, 1'b0, 1'b1, 5'd2, 16'h7777, "R11");
    step(16'h0000, 1'b0, 1'b1, 5'd9, 16'h5555, "R11");

    for (int n = 0; n < 3000; n++) begin
      ins  = 16'($urandom);
      mwe  = ($urandom % 5) == 0;
      msel = 5'($urandom % 18);
      mwd  = 16'($urandom);
      if (msel < 5'd4) mwd = mwd & 16'h0c3f;
      step(ins, 1'($urandom % 2), mwe, msel, mwd, mwe ? "R11" : fam(ins[7:0]));
    end
    step(16'h0000, 1'b0, 1'b0, 0, 0, "R2");
    step(16'h0000, 1'b0, 1'b0, 0, 0, "R2");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule